// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block gathers the event pulses of an SD/MMC host (command engine, data engine, card) into two 16-bit sticky status registers, one for normal events and one for errors, and drives a single level interrupt toward the processor. Each status register has two masks. The status-enable mask decides whether an event latches at all. The interrupt-enable mask decides whether a latched bit reaches the interrupt line.

Every latched error that is also interrupt-enabled is folded into a summary bit at the top of the normal status register. Software therefore needs only the normal register to see that an error is pending. Status bits are cleared by writing ones. Registers are reached through a simple write strobe and read strobe with a 3-bit word address. Read data is registered.

Top module: `sd_irq_ctrl`

## Requirements
- R1: After synchronous reset, every status register, mask, the card-check enable, `reg_rdata_o` and `irq_o` are zero.
- R2: A one-cycle pulse on an event input whose status-enable bit is 1 sets the matching status bit at that clock edge. The bit stays set until it is cleared. Normal event bits are: 0 command done, 1 transfer done, 2 auto-stop done, 3 unexpected response, 4 receive ready, 5 receive eight-word, 6 transmit available, 7 transmit eight-word, 8 card interrupt. Error bits are: 0 command timeout, 1 command CRC, 2 command end bit, 3 command index, 4 command start bit, 5 data timeout, 6 data CRC, 7 data end bit, 8 transfer size, 9 auto-stop error.
- R3: A status bit whose status-enable bit is 0 never latches. It reads as 0, and a bit already set is dropped on the next edge after its enable goes to 0.
- R4: Writing to a status register clears each bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFFFF clears all bits.
- R5: When an event and a clear of the same bit happen in the same cycle, the event wins and the bit stays set.
- R6: The card interrupt event (normal bit 8) latches only while the card-check enable (bit 0 at address 6) is 1.
- R7: Normal status bit 15 is an error summary. It reads 1 when any error status bit is set together with its error interrupt-enable bit, and normal status-enable bit 15 is 1. Writing to bit 15 has no effect on it.
- R8: `irq_o` is a register that goes high one clock after any bit of the normal status view (including bit 15) is set together with its normal interrupt-enable bit.
- R9: Address map: 0 normal status, 1 error status, 2 normal status-enable, 3 error status-enable, 4 normal interrupt-enable, 5 error interrupt-enable, 6 card-check enable (bit 0), 7 reads 0. A read strobe presents the addressed value on `reg_rdata_o` after the next clock edge. Mask registers read back what was written.
- R10: Normal status bits 9 to 14 and error status bits 10 to 15 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| norm_evt_i | input | 9 | Normal event pulses, bit order as in R2 |
| err_evt_i | input | 10 | Error event pulses, bit order as in R2 |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The assertions assume that every input holds a known value from the first edge after reset. They also assume that a mask takes effect for latching only from the edge after it is written, so their windows are phrased against the previous cycle's mask. The stimulus drives all inputs at the falling edge with defined values. Addresses are drawn from the full 3-bit range, and events and writes are mixed freely so that same-cycle event and clear collisions occur often.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
  localparam int ADDR_NSTAT = 0;
  localparam int ADDR_ESTAT = 1;
  localparam int ADDR_NSEN  = 2;
  localparam int ADDR_ESEN  = 3;
  localparam int ADDR_NIEN  = 4;
  localparam int ADDR_EIEN  = 5;
  localparam int ADDR_MODE  = 6;
endpackage

// File: rtl/sd_irq_stat_bank.sv
module sd_irq_stat_bank #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] sen_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] stat_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic clr_b;
    assign clr_b = clr_we_i & clr_mask_i[b];
    always_ff @(posedge clk) begin
      if (rst)
        stat_o[b] <= 1'b0;
      else
        stat_o[b] <= sen_i[b] & (evt_i[b] | (stat_o[b] & ~clr_b));
    end
  end
endmodule

// File: rtl/sd_irq_cfg.sv
module sd_irq_cfg #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] nsen_o,
  output logic [DW-1:0] esen_o,
  output logic [DW-1:0] nien_o,
  output logic [DW-1:0] eien_o,
  output logic          chk_en_o
);
  import sd_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      nsen_o   <= '0;
      esen_o   <= '0;
      nien_o   <= '0;
      eien_o   <= '0;
      chk_en_o <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == AW'(ADDR_NSEN)) nsen_o   <= wdata_i;
      if (addr_i == AW'(ADDR_ESEN)) esen_o   <= wdata_i;
      if (addr_i == AW'(ADDR_NIEN)) nien_o   <= wdata_i;
      if (addr_i == AW'(ADDR_EIEN)) eien_o   <= wdata_i;
      if (addr_i == AW'(ADDR_MODE)) chk_en_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/sd_irq_combine.sv
module sd_irq_combine #(
  parameter int DW = 16,
  parameter int NW = 9,
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] nstat_i,
  input  logic [EW-1:0] estat_i,
  input  logic [DW-1:0] nsen_i,
  input  logic [DW-1:0] nien_i,
  input  logic [DW-1:0] eien_i,
  output logic [DW-1:0] nview_o,
  output logic [DW-1:0] eview_o,
  output logic          irq_o
);
  localparam int SUM_IDX = DW - 1;
  localparam int GAP_W   = DW - 1 - NW;

  logic err_sum;

  assign err_sum = nsen_i[SUM_IDX] & (|(estat_i & eien_i[EW-1:0]));
  assign nview_o = {err_sum, {GAP_W{1'b0}}, nstat_i};
  assign eview_o = {{(DW-EW){1'b0}}, estat_i};

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(nview_o & nien_i);
  end
endmodule

// File: rtl/sd_irq_ctrl.sv
module sd_irq_ctrl #(
  parameter int DW = 16,
  parameter int NW = 9,
  parameter int EW = 10,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [NW-1:0] norm_evt_i,
  input  logic [EW-1:0] err_evt_i,
  output logic          irq_o
);
  import sd_irq_pkg::*;

  localparam int CARD_IDX = NW - 1;

  logic [DW-1:0] nsen, esen, nien, eien;
  logic          chk_en;
  logic [NW-1:0] norm_q_evt;
  logic [NW-1:0] norm_stat;
  logic [EW-1:0] err_stat;
  logic [DW-1:0] nview, eview;
  logic          nclr_we, eclr_we;
  logic [DW-1:0] rd_mux;

  sd_irq_cfg #(.DW(DW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .nsen_o(nsen), .esen_o(esen),
    .nien_o(nien), .eien_o(eien), .chk_en_o(chk_en)
  );

  // card interrupt is only seen while checking is enabled
  always_comb begin
    norm_q_evt           = norm_evt_i;
    norm_q_evt[CARD_IDX] = norm_evt_i[CARD_IDX] & chk_en;
  end

  assign nclr_we = reg_wr_i && (reg_addr_i == AW'(ADDR_NSTAT));
  assign eclr_we = reg_wr_i && (reg_addr_i == AW'(ADDR_ESTAT));

  sd_irq_stat_bank #(.W(NW)) u_nbank (
    .clk(clk), .rst(rst), .evt_i(norm_q_evt), .sen_i(nsen[NW-1:0]),
    .clr_we_i(nclr_we), .clr_mask_i(reg_wdata_i[NW-1:0]), .stat_o(norm_stat)
  );

  sd_irq_stat_bank #(.W(EW)) u_ebank (
    .clk(clk), .rst(rst), .evt_i(err_evt_i), .sen_i(esen[EW-1:0]),
    .clr_we_i(eclr_we), .clr_mask_i(reg_wdata_i[EW-1:0]), .stat_o(err_stat)
  );

  sd_irq_combine #(.DW(DW), .NW(NW), .EW(EW)) u_comb (
    .clk(clk), .rst(rst), .nstat_i(norm_stat), .estat_i(err_stat),
    .nsen_i(nsen), .nien_i(nien), .eien_i(eien),
    .nview_o(nview), .eview_o(eview), .irq_o(irq_o)
  );

  always_comb begin
    case (int'(reg_addr_i))
      ADDR_NSTAT: rd_mux = nview;
      ADDR_ESTAT: rd_mux = eview;
      ADDR_NSEN:  rd_mux = nsen;
      ADDR_ESEN:  rd_mux = esen;
      ADDR_NIEN:  rd_mux = nien;
      ADDR_EIEN:  rd_mux = eien;
      ADDR_MODE:  rd_mux = {{(DW-1){1'b0}}, chk_en};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/sd_irq_ctrl_chk.sv
module sd_irq_ctrl_chk #(
  parameter int DW = 16,
  parameter int NW = 9,
  parameter int EW = 10,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [NW-1:0] norm_evt_i,
  input logic [EW-1:0] err_evt_i,
  input logic          irq_o,
  input logic [NW-1:0] norm_stat,
  input logic [EW-1:0] err_stat,
  input logic [DW-1:0] nsen,
  input logic [DW-1:0] esen,
  input logic [DW-1:0] nien,
  input logic          chk_en
);
  import sd_irq_pkg::*;

  logic [EW-1:0] e_hit;
  logic [NW-2:0] n_race;
  assign e_hit  = err_evt_i & esen[EW-1:0];
  assign n_race = norm_evt_i[NW-2:0] & nsen[NW-2:0] & reg_wdata_i[NW-2:0];

  // R2
  err_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (e_hit != '0) |=> ((err_stat & $past(e_hit)) == $past(e_hit)));

  // R3
  err_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((err_stat & ~$past(esen[EW-1:0])) == '0));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == AW'(ADDR_ESTAT))
      |=> ((err_stat & $past(reg_wdata_i[EW-1:0] & ~err_evt_i)) == '0));

  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == AW'(ADDR_NSTAT) && n_race != '0)
      |=> ((norm_stat[NW-2:0] & $past(n_race)) == $past(n_race)));

  // R6
  card_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!chk_en && !norm_stat[NW-1]) |=> !norm_stat[NW-1]);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (nien == '0) |=> !irq_o);
endmodule

bind sd_irq_ctrl sd_irq_ctrl_chk #(.DW(DW), .NW(NW), .EW(EW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .norm_evt_i(norm_evt_i), .err_evt_i(err_evt_i),
  .irq_o(irq_o), .norm_stat(norm_stat), .err_stat(err_stat),
  .nsen(nsen), .esen(esen), .nien(nien), .chk_en(chk_en)
);

// File: tb/sd_irq_ctrl_bench.sv
module sd_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [8:0]  norm_evt_i = '0;
  logic [9:0]  err_evt_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  // bench model of the register state
  logic [8:0]  m_nstat = '0;
  logic [9:0]  m_estat = '0;
  logic [15:0] m_nse = '0, m_ese = '0, m_nie = '0, m_eie = '0;
  logic        m_chk = 1'b0;

  always #2 clk = ~clk;

  sd_irq_ctrl u_sd_irq_ctrl (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .norm_evt_i(norm_evt_i), .err_evt_i(err_evt_i), .irq_o(irq_o)
  );

  function automatic logic [15:0] exp_nview();
    logic sum;
    sum = m_nse[15] & (|(m_estat & m_eie[9:0]));
    return {sum, 6'b0, m_nstat};
  endfunction

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return exp_nview();
      3'd1: return {6'b0, m_estat};
      3'd2: return m_nse;
      3'd3: return m_ese;
      3'd4: return m_nie;
      3'd5: return m_eie;
      3'd6: return {15'b0, m_chk};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [8:0] ne, input logic [9:0] ee, input logic wr,
                      input logic rd, input logic [2:0] a, input logic [15:0] d,
                      input string tag);
    logic [15:0] e_rd;
    logic        e_irq;
    logic [8:0]  qe, clrn;
    logic [9:0]  clre;
    e_rd  = exp_read(a);
    e_irq = |(exp_nview() & m_nie);
    norm_evt_i = ne; err_evt_i = ee; reg_wr_i = wr; reg_rd_i = rd;
    reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R8 irq"}, {15'b0, irq_o}, {15'b0, e_irq});
    if (rd) check(tag, reg_rdata_o, e_rd);
    qe    = ne;
    qe[8] = ne[8] & m_chk;
    clrn  = (wr && a == 3'd0) ? d[8:0] : 9'h0;
    clre  = (wr && a == 3'd1) ? d[9:0] : 10'h0;
    m_nstat = m_nse[8:0] & (qe | (m_nstat & ~clrn));
    m_estat = m_ese[9:0] & (ee | (m_estat & ~clre));
    if (wr) begin
      case (a)
        3'd2: m_nse = d;
        3'd3: m_ese = d;
        3'd4: m_nie = d;
        3'd5: m_eie = d;
        3'd6: m_chk = d[0];
        default: ;
      endcase
    end
    norm_evt_i = '0; err_evt_i = '0; reg_wr_i = 1'b0; reg_rd_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(9'h0, 10'h0, 1'b0, 1'b1, a, 16'h0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    step(9'h0, 10'h0, 1'b1, 1'b0, a, d, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset");
    // R9 mask setup and readback
    wr(3'd2, 16'hFFFF, "R9");
    wr(3'd3, 16'hFFFF, "R9");
    rd(3'd2, "R9 nse readback");
    rd(3'd3, "R9 ese readback");
    // R2 latching
    step(9'h001, 10'h0, 1'b0, 1'b0, 3'd0, 16'h0, "R2 norm evt");
    rd(3'd0, "R2 norm latched");
    step(9'h0, 10'h008, 1'b0, 1'b0, 3'd0, 16'h0, "R2 err evt");
    rd(3'd1, "R2 err latched");
    rd(3'd0, "R7 no summary without ie");
    // R7 summary
    wr(3'd5, 16'hFFFF, "R7");
    rd(3'd0, "R7 summary set");
    wr(3'd4, 16'h8000, "R8");
    rd(3'd0, "R8 irq from summary");
    wr(3'd0, 16'h8000, "R7 write summary");
    rd(3'd0, "R7 summary unaffected");
    // R4 clear all errors
    wr(3'd1, 16'hFFFF, "R4");
    rd(3'd1, "R4 all cleared");
    rd(3'd0, "R7 summary gone");
    // R5 event beats clear
    step(9'h002, 10'h0, 1'b1, 1'b0, 3'd0, 16'h0002, "R5 race");
    rd(3'd0, "R5 event wins");
    wr(3'd0, 16'h0001, "R4 partial");
    rd(3'd0, "R4 partial clear");
    // R6 card interrupt gating
    step(9'h100, 10'h0, 1'b0, 1'b0, 3'd0, 16'h0, "R6 card off");
    rd(3'd0, "R6 card ignored");
    wr(3'd6, 16'h0001, "R6");
    step(9'h100, 10'h0, 1'b0, 1'b0, 3'd0, 16'h0, "R6 card on");
    rd(3'd0, "R6 card latched");
    // R3 status-enable gating
    wr(3'd2, 16'hFFFD, "R3");
    rd(3'd0, "R3 dropped");
    step(9'h002, 10'h0, 1'b0, 1'b0, 3'd0, 16'h0, "R3 pulse");
    rd(3'd0, "R3 never latches");
    // R10 unused bits
    wr(3'd2, 16'hFFFF, "R10");
    step(9'h1FF, 10'h3FF, 1'b0, 1'b0, 3'd0, 16'h0, "R10 all evts");
    wr(3'd0, 16'h7E00, "R10 write unused");
    rd(3'd0, "R10 norm unused");
    rd(3'd1, "R10 err unused");
    rd(3'd7, "R9 empty addr");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [8:0]  ne;
      logic [9:0]  ee;
      logic        w;
      logic [2:0]  a;
      logic [15:0] d;
      ne = 9'($urandom & $urandom & $urandom);
      ee = 10'($urandom & $urandom & $urandom);
      w  = ($urandom % 4) == 0;
      a  = 3'($urandom);
      d  = ((a == 3'd2 || a == 3'd3) && ($urandom % 2)) ? 16'hFFFF : 16'($urandom);
      step(ne, ee, w, ($urandom % 2) == 1, a, d, "R2 random");
    end
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule